// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a small status register that tells software which reset source caused the most recent restart of the device. Four single-cycle event inputs report a power-on reset, a reset from the external pin, a brown-out reset and a watchdog system reset. Each event latches its own flag. The flags stay set until they are cleared, so a program can read the register early after start-up, find out why it restarted, and then clear it.

Software reaches the register through a plain register bus with an address, a write enable, write data and combinational read data. Writes clear flags by writing zero to them. A flag written with one keeps its value. A power-on event gives the register a clean history: it sets the power-on flag and clears the other three. The power-on flag itself is never cleared by hardware. The upper half of the byte is reserved.

Top module: `reset_cause_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags clear, so the register reads 0x00 afterwards.
- R2: Bits 7 to 4 always read as zero. Writing ones to them has no effect on any bit.
- R3: A pulse on `evt_wdt` sets bit 3 at the next clock edge.
- R4: A pulse on `evt_bod` sets bit 2 and a pulse on `evt_ext` sets bit 1, each at the next clock edge.
- R5: A pulse on `evt_por` sets bit 0 and clears bits 3 to 1 at the next clock edge. This holds even if other events or writes occur in the same cycle, so the result is 0x01.
- R6: Only a register write with bit 0 equal to zero clears bit 0. No event clears it.
- R7: A write to the register address clears every flag whose write-data bit is zero and leaves every flag whose write-data bit is one unchanged.
- R8: When a flag's event and a write of zero to that flag happen in the same cycle, the flag ends up set.
- R9: Flags are not cleared by external, brown-out or watchdog events, so several flags can be set at the same time.
- R10: `bus_rdata` is zero when `bus_addr` differs from `REG_ADDR`, and a write to any other address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the register flops |
| evt_por | input | 1 | Power-on reset event pulse |
| evt_ext | input | 1 | External pin reset event pulse |
| evt_bod | input | 1 | Brown-out reset event pulse |
| evt_wdt | input | 1 | Watchdog system reset event pulse |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational |

## Verification
The assertions check several rules on every cycle inside each flag cell. An event sets its flag unless a power-on clear takes precedence. A power-on clear empties the flag. A write of zero with no competing set clears the flag, and a flag with no trigger holds its value. At the top level, bit 0 only ever falls after a matching write of zero, and the reserved bits never read as one. The bench scenarios are what show the combined effects, which no single cycle reveals. These are the 0x01 result of a power-on that coincides with other events and writes, flags that accumulate over many resets, writes of ones that change nothing, and writes to other addresses that are ignored. A reference model compares these cases against a long random mix of events and writes.

// File: rtl/rcf_pkg.sv
// Package: shared widths and flag bit positions for the reset cause register.
// Assumes software decodes the flag bits at the positions given here.
package rcf_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 4;
    localparam int BIT_POR   = 0;
    localparam int BIT_EXT   = 1;
    localparam int BIT_BOD   = 2;
    localparam int BIT_WDT   = 3;
    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rcf_flag_cell.sv
// Module: one sticky reset-cause flag.
// Priority: hardware clear, then set event, then software write-zero, else hold.
// Assumes set_i and hw_clr_i are single-cycle pulses synchronous to clk.
module rcf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o
);
    logic sw_clr;

    // Software clears the flag by writing a zero to its bit.
    always_comb sw_clr = wr_i && !wbit_i;

    // Flag state update with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        q_o <= 1'b0;
        else if (hw_clr_i) q_o <= 1'b0;
        else if (set_i)    q_o <= 1'b1;
        else if (sw_clr)   q_o <= 1'b0;
    end

    // R3 R4 R8: an event wins over a software clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !hw_clr_i) |=> q_o);
    // R5: hardware clear empties the flag
    p_hw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_i |=> !q_o);
    // R7: write of zero with no competing set clears
    p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wbit_i && !set_i && !hw_clr_i) |=> !q_o);
    // R7: no trigger means the flag holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !hw_clr_i && !(wr_i && !wbit_i)) |=> $stable(q_o));
endmodule

// File: rtl/rcf_bus_decode.sv
// Module: address decode and read mux for the flag register.
// Assumes a single register at REG_ADDR. Reads are combinational and return zero elsewhere.
module rcf_bus_decode
    import rcf_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  flag_vec_t         flags_i,
    output logic              wr_hit_o,
    output flag_vec_t         wbits_o,
    output logic [REG_W-1:0]  rdata_o
);
    logic sel;

    // Address match for this register.
    always_comb sel = (addr_i == REG_ADDR);

    // Write strobe and write bits routed to the flag cells.
    always_comb begin
        wr_hit_o = sel && we_i;
        wbits_o  = wdata_i[NUM_FLAGS-1:0];
    end

    // Read mux, reserved bits tied low.
    always_comb begin
        rdata_o = '0;
        if (sel) rdata_o[NUM_FLAGS-1:0] = flags_i;
    end

    // R2: writing ones to reserved bits never shows up on the read port
    p_rsvd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_o && (wdata_i[REG_W-1:NUM_FLAGS] != '0)) |=> (rdata_o[REG_W-1:NUM_FLAGS] == '0));
    // R10: unselected address reads zero
    p_unsel_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata_o == '0));
endmodule

// File: rtl/reset_cause_flags.sv
// Module: reset cause flag register top.
// Captures the four reset event pulses into sticky flags. A power-on event
// clears all other flags. Software clears flags by writing zero.
// Assumes event pulses are already synchronous to clk. Synchronous active-low reset.
module reset_cause_flags
    import rcf_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_por,
    input  logic              evt_ext,
    input  logic              evt_bod,
    input  logic              evt_wdt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata
);
    flag_vec_t evt_vec;
    flag_vec_t flags;
    flag_vec_t wbits;
    logic      wr_hit;

    // Gather the event pulses by flag bit position.
    always_comb begin
        evt_vec          = '0;
        evt_vec[BIT_POR] = evt_por;
        evt_vec[BIT_EXT] = evt_ext;
        evt_vec[BIT_BOD] = evt_bod;
        evt_vec[BIT_WDT] = evt_wdt;
    end

    rcf_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .flags_i  (flags),
        .wr_hit_o (wr_hit),
        .wbits_o  (wbits),
        .rdata_o  (bus_rdata)
    );

    // One cell per flag. The power-on flag has no hardware clear.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic hw_clr;
        if (i == BIT_POR) begin : g_por
            always_comb hw_clr = 1'b0;
        end else begin : g_other
            always_comb hw_clr = evt_por;
        end
        rcf_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_vec[i]),
            .hw_clr_i (hw_clr),
            .wr_i     (wr_hit),
            .wbit_i   (wbits[i]),
            .q_o      (flags[i])
        );
    end

    // R6: the power-on flag only falls after a matching write of zero
    p_por_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[BIT_POR]) |-> $past(wr_hit && !bus_wdata[BIT_POR]));
    // R5: a power-on event yields exactly the power-on flag
    p_por_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_por |=> (flags == flag_vec_t'(1) << BIT_POR));
endmodule

// File: tb/reset_cause_flags_tb.sv
module reset_cause_flags_tb;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] REG_ADDR = 6'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_por = 0, evt_ext = 0, evt_bod = 0, evt_wdt = 0;
    logic [ADDR_W-1:0] bus_addr = REG_ADDR;
    logic bus_we = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] model = '0;

    always #4 clk = ~clk;

    reset_cause_flags #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_por(evt_por), .evt_ext(evt_ext),
        .evt_bod(evt_bod), .evt_wdt(evt_wdt), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic logic [3:0] next_flags(logic [3:0] cur, logic por, logic ext,
            logic bod, logic wdt, logic wr, logic [7:0] wd);
        logic [3:0] sets = {wdt, bod, ext, por};
        logic [3:0] nx = cur;
        for (int i = 0; i < 4; i++) begin
            if (i != 0 && por) nx[i] = 1'b0;
            else if (sets[i])  nx[i] = 1'b1;
            else if (wr && !wd[i]) nx[i] = 1'b0;
        end
        return nx;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One clocked operation, then a read of the register away from the edge.
    task automatic step(string req, logic por, logic ext, logic bod, logic wdt,
            logic we, logic [ADDR_W-1:0] addr, logic [7:0] wd);
        @(negedge clk);
        evt_por = por; evt_ext = ext; evt_bod = bod; evt_wdt = wdt;
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        #1;
        model = next_flags(model, por, ext, bod, wdt, we && (addr == REG_ADDR), wd);
        evt_por = 0; evt_ext = 0; evt_bod = 0; evt_wdt = 0;
        bus_we = 0; bus_addr = REG_ADDR; bus_wdata = '0;
        #1;
        check(req, bus_rdata, {4'b0, model});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] other = REG_ADDR ^ 6'h01;
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        model = '0;
        check("R1", bus_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        // R3, R4: single events
        step("R3", 0,0,0,1, 0, REG_ADDR, 8'h00);
        step("R7", 0,0,0,0, 1, REG_ADDR, 8'hF7);
        step("R4", 0,0,1,0, 0, REG_ADDR, 8'h00);
        step("R4", 0,1,0,0, 0, REG_ADDR, 8'h00);
        // R9: accumulation
        step("R9", 0,0,0,1, 0, REG_ADDR, 8'h00);
        check("R9", bus_rdata, 8'h0E);
        // R7: writing ones leaves flags alone; R2 reserved ignored
        step("R7", 0,0,0,0, 1, REG_ADDR, 8'hFF);
        check("R2", bus_rdata, 8'h0E);
        // R10: other address
        step("R10", 0,0,0,0, 1, other, 8'h00);
        @(negedge clk); bus_addr = other; #1;
        check("R10", bus_rdata, 8'h00);
        bus_addr = REG_ADDR;
        // R8: set wins over write zero
        step("R8", 0,0,1,0, 1, REG_ADDR, 8'h00);
        check("R8", bus_rdata, 8'h04);
        // R5: power-on with concurrent events and write
        step("R5", 0,1,0,1, 0, REG_ADDR, 8'h00);
        step("R5", 1,1,1,1, 1, REG_ADDR, 8'h00);
        check("R5", bus_rdata, 8'h01);
        // R6: events do not clear the power-on flag
        step("R6", 0,1,1,1, 0, REG_ADDR, 8'h00);
        check("R6", bus_rdata, 8'h0F);
        step("R6", 0,0,0,0, 1, REG_ADDR, 8'hFE);
        check("R6", bus_rdata, 8'h0E);
        step("R2", 0,0,0,0, 1, REG_ADDR, 8'hF0);
        // Random mix, checked against the model (R7 and others)
        for (int k = 0; k < 400; k++) begin
            logic [7:0] r = 8'($urandom);
            step("R7", ($urandom % 16) == 0, r[0] & r[1], r[2] & r[3], r[4] & r[5],
                 r[6], (($urandom % 4) == 0) ? other : REG_ADDR, 8'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule